// File: doc/BRIEF.md
# Interleaved Multiplexed Display Scan Timer

This block generates the timing skeleton for a nine-position multiplexed vacuum fluorescent display whose positions are not visited left to right but in an interleaved order. Every clock is one state. A digit time spans sixteen states. After every third digit time, a four-state keyboard window lets the key matrix be sampled in parallel. One full scan is three groups of three digit times each, with one keyboard window per group, for 156 states in total.

The block drives a one-hot digit enable and a digit index that a separate segment lookup uses to fetch the segment pattern. It also drives the state count inside the current digit or keyboard time, a keyboard-window strobe and a one-cycle pulse that marks the last state of the scan. Positions 1 to 8 hold the number, with position 1 least significant. Position 9 holds the sign. A count of significant digits and a sign request from the number formatter decide which positions are actually lit, so leading zeros stay dark. Segment decoding and key detection belong to other blocks.

Top module: `vfd_scan_sequencer`

## Requirements
- R1: A synchronous active-low reset places the scan at the first state of position 1: `state` = 0, `dig_idx` = 0, `kb_win` = 0, `frame_end` = 0 and `dig_en` = 0. The next released clock advances from there.
- R2: In a digit time, `state` counts 0 to 15 and advances by one on every clock. It returns to 0 when the next digit time or keyboard window begins.
- R3: `dig_idx` is the position number minus one. Digit times visit indices 0,3,6, then 1,4,7, then 2,5,8, and then the order repeats.
- R4: A keyboard window of four states (`kb_win` = 1, `state` 0 to 3) follows every third digit time. No bit of `dig_en` is set during the window.
- R5: `dig_en` is all zero in state 0 and in state 15 of every digit time.
- R6: In states 1 to 14 of a digit time, `dig_en` is either zero or has exactly one bit set, namely bit `dig_idx`. Bit i drives position i+1.
- R7: A numeric index i (0 to 7) is lit when i < L. L is `sig_digits`, with 0 taken as 1 and any value above 8 taken as 8. So with a count of 0 or 1, only position 1 lights.
- R8: Index 8, the sign position, is lit only while `sign_on` is 1.
- R9: `frame_end` is 1 on the last state of the third keyboard window and 0 in every other state. It therefore repeats every 156 clocks.
- R10: During a keyboard window, `dig_idx` keeps the index of the digit time that just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, one state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_digits | input | 4 | Number of significant numeric positions requested |
| sign_on | input | 1 | Request to light the sign position |
| dig_en | output | 9 | One-hot digit driver enable, bit 0 = position 1 |
| dig_idx | output | 4 | Index of the position in the current digit time |
| state | output | 4 | State count within the current digit time or keyboard window |
| kb_win | output | 1 | High during a keyboard window |
| frame_end | output | 1 | High on the last state of a full scan |

## Verification
Three events coincide on the final keyboard state of a scan: the keyboard window closes, the group counter wraps, and the scan-end pulse fires. The very next clock must then show position 1 in state 0. The bench runs repeatedly across this boundary and compares every output each cycle with a position model it computes for itself. It also counts the pulses over two whole scans. A second coincidence is the significant-digit limit changing while blanking is active. The bench changes `sig_digits` and `sign_on` between whole scans and expects blanking to win in states 0 and 15 whatever those inputs say.

// File: rtl/vfd_scan_pkg.sv
`timescale 1ns/1ps
// Shared types for the interleaved display scan timer.
// Assumes: no other package defines these names.
package vfd_scan_pkg;

    // Whether the scan is in a digit time or in a keyboard window.
    typedef enum logic {
        PH_DIGIT = 1'b0,
        PH_KEYS  = 1'b1
    } scan_phase_t;

endpackage

// File: rtl/scan_timebase.sv
`timescale 1ns/1ps
// Counts states inside a digit time or a keyboard window and chooses
// which of the two comes next.
// Assumes: KB_STATES <= SPD, so one counter width is enough for both.
module scan_timebase
    import vfd_scan_pkg::*;
#(
    parameter int SPD       = 16,
    parameter int KB_STATES = 4,
    localparam int SW       = $clog2(SPD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_slot,
    output logic [SW-1:0]     state,
    output scan_phase_t       phase,
    output logic              span_last
);

    localparam logic [SW-1:0] DIG_LAST = SW'(SPD - 1);
    localparam logic [SW-1:0] KB_LAST  = SW'(KB_STATES - 1);

    // Flag the final state of the current span.
    always_comb begin
        span_last = (phase == PH_DIGIT) ? (state == DIG_LAST) : (state == KB_LAST);
    end

    // Advance the state count and switch phase at the end of a span.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
            phase <= PH_DIGIT;
        end else if (span_last) begin
            state <= '0;
            phase <= (phase == PH_DIGIT && last_slot) ? PH_KEYS : PH_DIGIT;
        end else begin
            state <= state + SW'(1);
        end
    end

endmodule

// File: rtl/scan_order_seq.sv
`timescale 1ns/1ps
// Keeps the slot within a group and the group within a scan, and forms
// the interleaved position index idx = group + N_GROUPS * slot.
// Assumes: SLOTS * N_GROUPS positions in all, N_GROUPS >= 2.
module scan_order_seq #(
    parameter int SLOTS    = 3,
    parameter int N_GROUPS = 3,
    localparam int N_POS   = SLOTS * N_GROUPS,
    localparam int IDXW    = $clog2(N_POS),
    localparam int KW      = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int GW      = $clog2(N_GROUPS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            digit_end,
    input  logic            kb_end,
    output logic            last_slot,
    output logic            last_group,
    output logic [IDXW-1:0] idx
);

    logic [KW-1:0] slot;
    logic [GW-1:0] group;

    // Detect the final slot and the final group.
    always_comb begin
        last_slot  = (slot  == KW'(SLOTS - 1));
        last_group = (group == GW'(N_GROUPS - 1));
        idx        = IDXW'(group) + IDXW'(N_GROUPS) * IDXW'(slot);
    end

    // Step the slot after each digit time, and the group after each keyboard window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot  <= '0;
            group <= '0;
        end else if (kb_end) begin
            slot  <= '0;
            group <= last_group ? '0 : group + GW'(1);
        end else if (digit_end && !last_slot) begin
            slot  <= slot + KW'(1);
        end
    end

endmodule

// File: rtl/digit_enable_dec.sv
`timescale 1ns/1ps
// Turns the current position into a one-hot driver enable. Positions
// beyond the significant count stay dark; the top position is the sign.
// Assumes: the top position is the sign and all the others are numeric.
module digit_enable_dec #(
    parameter int N_POS = 9,
    localparam int IDXW = $clog2(N_POS),
    localparam int NUM  = N_POS - 1
) (
    input  logic             show,
    input  logic [IDXW-1:0]  idx,
    input  logic [IDXW-1:0]  sig_digits,
    input  logic             sign_on,
    output logic [N_POS-1:0] dig_en
);

    logic [IDXW-1:0]  limit;
    logic [N_POS-1:0] pos_ok;

    // Clamp the significant count to the range 1..NUM.
    always_comb begin
        if (sig_digits == '0)                 limit = IDXW'(1);
        else if (sig_digits > IDXW'(NUM))     limit = IDXW'(NUM);
        else                                  limit = sig_digits;
    end

    // One enable cell per position; the top one follows the sign request.
    for (genvar i = 0; i < N_POS; i++) begin : g_pos
        if (i == N_POS - 1) begin : g_sign
            assign pos_ok[i] = sign_on;
        end else begin : g_num
            assign pos_ok[i] = (IDXW'(i) < limit);
        end
        assign dig_en[i] = show && (idx == IDXW'(i)) && pos_ok[i];
    end

endmodule

// File: rtl/vfd_scan_sequencer.sv
`timescale 1ns/1ps
// Top of the interleaved display scan timer. It joins the state timebase,
// the order sequencer and the enable decoder, and blanks the drivers in
// the first and last state of each digit time.
// Assumes: SPD >= 3 so that there are unblanked states.
module vfd_scan_sequencer
    import vfd_scan_pkg::*;
#(
    parameter int SLOTS     = 3,
    parameter int N_GROUPS  = 3,
    parameter int SPD       = 16,
    parameter int KB_STATES = 4,
    localparam int N_POS    = SLOTS * N_GROUPS,
    localparam int IDXW     = $clog2(N_POS),
    localparam int SW       = $clog2(SPD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDXW-1:0]  sig_digits,
    input  logic             sign_on,
    output logic [N_POS-1:0] dig_en,
    output logic [IDXW-1:0]  dig_idx,
    output logic [SW-1:0]    state,
    output logic             kb_win,
    output logic             frame_end
);

    scan_phase_t phase;
    logic        span_last;
    logic        last_slot;
    logic        last_group;
    logic        show;

    scan_timebase #(.SPD(SPD), .KB_STATES(KB_STATES)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_slot (last_slot),
        .state     (state),
        .phase     (phase),
        .span_last (span_last)
    );

    scan_order_seq #(.SLOTS(SLOTS), .N_GROUPS(N_GROUPS)) u_ord (
        .clk        (clk),
        .rst_n      (rst_n),
        .digit_end  (span_last && phase == PH_DIGIT),
        .kb_end     (span_last && phase == PH_KEYS),
        .last_slot  (last_slot),
        .last_group (last_group),
        .idx        (dig_idx)
    );

    // Drivers may light only inside a digit time, away from both edges.
    always_comb begin
        show      = (phase == PH_DIGIT) && (state != '0) && (state != SW'(SPD - 1));
        kb_win    = (phase == PH_KEYS);
        frame_end = (phase == PH_KEYS) && span_last && last_group;
    end

    digit_enable_dec #(.N_POS(N_POS)) u_dec (
        .show       (show),
        .idx        (dig_idx),
        .sig_digits (sig_digits),
        .sign_on    (sign_on),
        .dig_en     (dig_en)
    );

endmodule

// File: rtl/vfd_scan_sva.sv
`timescale 1ns/1ps
// Property checker for the scan timer, attached through bind.
// Assumes: default parameters of the top module.
module vfd_scan_sva #(
    parameter int N_POS = 9,
    parameter int SPD   = 16,
    parameter int KBS   = 4,
    localparam int IDXW = $clog2(N_POS),
    localparam int SW   = $clog2(SPD)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDXW-1:0]  sig_digits,
    input logic             sign_on,
    input logic [N_POS-1:0] dig_en,
    input logic [IDXW-1:0]  dig_idx,
    input logic [SW-1:0]    state,
    input logic             kb_win,
    input logic             frame_end
);

    p_reset_home_r1: assert property (@(posedge clk)
        !rst_n |=> (state == '0 && dig_idx == '0 && !kb_win && dig_en == '0));

    p_state_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!kb_win && state != SW'(SPD - 1)) |=> (!kb_win && state == $past(state) + SW'(1)));

    p_kb_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        kb_win |-> dig_en == '0);

    p_kb_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_win && state == SW'(KBS - 1)) |=> (!kb_win && state == '0));

    p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!kb_win && (state == '0 || state == SW'(SPD - 1))) |-> dig_en == '0);

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en));

    p_match_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en != '0) |-> (dig_en == (N_POS'(1) << dig_idx)));

    p_sign_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dig_en[N_POS-1] |-> sign_on);

    p_frame_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (kb_win && state == SW'(KBS - 1)));

    p_frame_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (!kb_win && state == '0 && dig_idx == '0));

    p_kb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        kb_win |-> $stable(dig_idx));

endmodule

bind vfd_scan_sequencer vfd_scan_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_digits (sig_digits),
    .sign_on    (sign_on),
    .dig_en     (dig_en),
    .dig_idx    (dig_idx),
    .state      (state),
    .kb_win     (kb_win),
    .frame_end  (frame_end)
);

// File: tb/vfd_scan_sequencer_tb.sv
`timescale 1ns/1ps
// Directed bench for the scan timer: a scan-position model in the bench
// predicts every output on every cycle.
module vfd_scan_sequencer_tb;

    localparam int FRAME = 156;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sig_digits = 4'd1;
    logic       sign_on = 1'b0;
    logic [8:0] dig_en;
    logic [3:0] dig_idx;
    logic [3:0] state;
    logic       kb_win;
    logic       frame_end;

    int n_chk = 0;
    int n_bad = 0;
    int pos   = 0;
    bit done  = 1'b0;

    vfd_scan_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .sig_digits(sig_digits), .sign_on(sign_on),
        .dig_en(dig_en), .dig_idx(dig_idx), .state(state),
        .kb_win(kb_win), .frame_end(frame_end)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s pos=%0d actual=%0h expected=%0h", tag, pos, act, exp);
        end
    endtask

    // Compare every output with the scan-position model.
    task automatic check_all();
        int g, r, s, idx, lim;
        bit kb, ok;
        logic [8:0] en;
        g = pos / 52;
        r = pos % 52;
        if (r < 48) begin kb = 0; s = r % 16; idx = g + 3 * (r / 16); end
        else begin kb = 1; s = r - 48; idx = g + 6; end
        lim = (sig_digits == 0) ? 1 : ((sig_digits > 8) ? 8 : int'(sig_digits));
        ok  = (idx == 8) ? sign_on : (idx < lim);
        en  = (!kb && s != 0 && s != 15 && ok) ? (9'd1 << idx) : 9'd0;
        chk("R2 state", 16'(state), 16'(s));
        chk(kb ? "R10 idx hold" : "R3 idx", 16'(dig_idx), 16'(idx));
        chk("R4 kb_win", 16'(kb_win), 16'(kb));
        if (kb)                  chk("R4 dig_en in window", 16'(dig_en), 16'(en));
        else if (s == 0 || s == 15) chk("R5 blank", 16'(dig_en), 16'(en));
        else if (idx == 8)       chk("R8 sign", 16'(dig_en), 16'(en));
        else if (en != 0)        chk("R6 one-hot", 16'(dig_en), 16'(en));
        else                     chk("R7 dark", 16'(dig_en), 16'(en));
        chk("R9 frame_end", 16'(frame_end), 16'(pos == FRAME - 1));
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            pos = (pos + 1) % FRAME;
            #2;
            check_all();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        pos = 0;
    endtask

    // R1: the reset state.
    task automatic t_reset_state();
        do_reset();
        chk("R1 state", 16'(state), 16'd0);
        chk("R1 idx", 16'(dig_idx), 16'd0);
        chk("R1 kb_win", 16'(kb_win), 16'd0);
        chk("R1 dig_en", 16'(dig_en), 16'd0);
        chk("R1 frame_end", 16'(frame_end), 16'd0);
    endtask

    // R7: a count of zero lights only position 1.
    task automatic t_zero_display();
        sig_digits = 4'd0; sign_on = 1'b0;
        step(FRAME);
    endtask

    // R3: the visit order, captured at state 1 of each digit time.
    task automatic t_order();
        int seen[9];
        int n = 0;
        int want[9] = '{0, 3, 6, 1, 4, 7, 2, 5, 8};
        sig_digits = 4'd8; sign_on = 1'b1;
        step(FRAME - pos);
        for (int i = 0; i < FRAME; i++) begin
            step(1);
            if (!kb_win && state == 4'd1 && n < 9) begin
                seen[n] = int'(dig_idx);
                n++;
            end
        end
        chk("R3 digit times seen", 16'(n), 16'd9);
        for (int i = 0; i < 9; i++) chk("R3 order", 16'(seen[i]), 16'(want[i]));
    endtask

    // R7, R8: sweep the significant count and the sign request.
    task automatic t_sig_sweep();
        for (int v = 0; v <= 10; v++) begin
            sig_digits = 4'(v);
            sign_on = v[0];
            step(FRAME);
        end
    endtask

    // R9: exactly one scan-end pulse per 156 clocks.
    task automatic t_frame_pulses();
        int cnt = 0;
        for (int i = 0; i < 2 * FRAME; i++) begin
            step(1);
            if (frame_end) cnt++;
        end
        chk("R9 pulse count", 16'(cnt), 16'd2);
    endtask

    // R1: a reset in mid-scan returns to position 1, state 0.
    task automatic t_mid_reset();
        step(70);
        do_reset();
        chk("R1 mid idx", 16'(dig_idx), 16'd0);
        chk("R1 mid state", 16'(state), 16'd0);
        chk("R1 mid kb_win", 16'(kb_win), 16'd0);
        step(60);
    endtask

    initial begin
        t_reset_state();
        t_zero_display();
        t_order();
        t_sig_sweep();
        t_frame_pulses();
        t_mid_reset();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog pos=%0d actual=running expected=finished", pos);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule